// File: doc/BRIEF.md
# Dual-Product Packed Multiplier

The block forms two signed products that share one multiplier value by issuing a single wide signed multiplication. The two signed multiplicands are placed side by side in one wide operand: the low multiplicand sits in a low field of `LO_W` bits as a two's-complement value, a gap of `B_W` zero bits follows, and the high multiplicand occupies the top bits. One multiply by the shared value then yields a result in which both products are laid next to each other. The block slices them apart and repairs the low product when the low multiplicand is negative.

When the low multiplicand is negative, its field in the packed word reads as an unsigned number that is `2^LO_W` too large. The raw low result is therefore off by the shared value shifted left by `LO_W` bits, and the block subtracts that term. The high product comes out of the bits above the combined separation `SEP = LO_W + B_W`. A carry is added there when the low part of the result is negative, because that low part has borrowed from the high field. With the defaults (`A_W = 8`, `B_W = 8`, `LO_W = 9`) the packed operand is 25 bits wide and the raw result is 33 bits. For example, a shared value of 23 with multiplicands -90 (high) and -43 (low) gives a raw low field of 10787. After the correction term of 23·512 is removed, the outputs are -2070 and -989.

The datapath has three register stages: pack, multiply, and split/correct. A valid flag travels alongside the data. Accumulation of the products is left to the surrounding logic.

Top module: `dual_product_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and both products read 0 until the first valid input has passed through the pipeline.
- R2: `out_valid` equals `in_valid` from exactly three rising clock edges earlier, and each result appears on the cycle its `out_valid` is high.
- R3: With `out_valid` high, `prod_hi` equals the signed product of the `mcand_hi` and `mplier` values accepted three cycles earlier, for every pair of signed values.
- R4: With `out_valid` high, `prod_lo` equals the signed product of `mcand_lo` and `mplier`, for every pair of signed values, negative low multiplicands included.
- R5: Shared value 23 with high multiplicand -90 and low multiplicand -43 yields `prod_hi` = -2070 and `prod_lo` = -989.
- R6: Both fields at their extremes in the same word (for example -128 × -128 = 16384 in both) produce correct products with no interference between the fields.
- R7: Inputs presented while `in_valid` is low are ignored: both products keep the last valid result while `out_valid` is low.
- R8: A configuration with 12-bit multiplicands, a 9-bit shared value and a 12-bit low field (42-bit raw result) yields correct signed products for both fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on this cycle are to be processed |
| mcand_lo | input | A_W | Signed multiplicand placed in the low field |
| mcand_hi | input | A_W | Signed multiplicand placed in the high field |
| mplier | input | B_W | Signed multiplier shared by both products |
| out_valid | output | 1 | Products on this cycle are valid |
| prod_lo | output | A_W+B_W | Signed product mcand_lo × mplier |
| prod_hi | output | A_W+B_W | Signed product mcand_hi × mplier |

## Verification
A defect in the packing, the field slicing or the correction shows up at the ports three cycles after the faulty operands go in.

- A missing or misplaced correction gives a low product that is wrong by a multiple of the shared value for exactly the negative low multiplicands.
- A lost borrow leaves the high product off by one whenever the raw low part is negative.
- A valid flag out of step shows as an output strobe that arrives one cycle early or late.
- A load enable that ignores the valid flag lets idle-cycle garbage replace the held results.

Sweeping every low/shared pair and every high/shared pair therefore exposes each of these faults within a few cycles of the first affected operand.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

   // Bit distance between the low field start and the high field start.
   function automatic int sep_bits(input int lo_w, input int b_w);
      return lo_w + b_w;
   endfunction

   // Width of the packed wide operand.
   function automatic int pack_bits(input int a_w, input int lo_w, input int b_w);
      return a_w + lo_w + b_w;
   endfunction

   // Width of the full raw product.
   function automatic int raw_bits(input int a_w, input int lo_w, input int b_w);
      return a_w + lo_w + 2 * b_w;
   endfunction

endpackage

// File: rtl/dpu_pack.sv
module dpu_pack
   import dpu_pkg::*;
#(
   parameter int A_W  = 8,
   parameter int B_W  = 8,
   parameter int LO_W = 9
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    v_in,
   input  logic [A_W-1:0]                          lo_in,
   input  logic [A_W-1:0]                          hi_in,
   input  logic [B_W-1:0]                          m_in,
   output logic                                    v_q,
   output logic [pack_bits(A_W, LO_W, B_W)-1:0]    word_q,
   output logic [B_W-1:0]                          m_q,
   output logic                                    neg_q
);
   localparam int PACK_W = pack_bits(A_W, LO_W, B_W);

   logic [LO_W-1:0]   lo_field;
   logic [PACK_W-1:0] word_d;

   // Low multiplicand as a LO_W-bit two's-complement field.
   generate
      if (LO_W > A_W) begin : g_lo_extend
         assign lo_field = {{(LO_W - A_W){lo_in[A_W-1]}}, lo_in};
      end else begin : g_lo_direct
         assign lo_field = lo_in;
      end
   endgenerate

   // High multiplicand on top, B_W guard zeros, then the low field.
   assign word_d = {hi_in, {B_W{1'b0}}, lo_field};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         word_q <= '0;
         m_q    <= '0;
         neg_q  <= 1'b0;
      end else begin
         v_q <= v_in;
         if (v_in) begin
            word_q <= word_d;
            m_q    <= m_in;
            neg_q  <= lo_in[A_W-1];
         end
      end
   end

   // R2: stage valid follows its input by one edge.
   assert_pack_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (v_q == $past(v_in)));

   // R4: the sign flag travels with the packed word of the same operands.
   assert_pack_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(v_in)) |-> (neg_q == word_q[LO_W-1]));

endmodule

// File: rtl/dpu_mult.sv
module dpu_mult
   import dpu_pkg::*;
#(
   parameter int A_W  = 8,
   parameter int B_W  = 8,
   parameter int LO_W = 9
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  v_in,
   input  logic [pack_bits(A_W, LO_W, B_W)-1:0]  word_in,
   input  logic [B_W-1:0]                        m_in,
   input  logic                                  neg_in,
   output logic                                  v_q,
   output logic [raw_bits(A_W, LO_W, B_W)-1:0]   raw_q,
   output logic [B_W-1:0]                        m_q,
   output logic                                  neg_q
);
   localparam int PACK_W = pack_bits(A_W, LO_W, B_W);
   localparam int RAW_W  = raw_bits(A_W, LO_W, B_W);

   logic signed [RAW_W-1:0] word_x;
   logic signed [RAW_W-1:0] m_x;
   logic signed [RAW_W-1:0] raw_d;

   // Both operands sign-extended to the full result width, so the
   // truncated product equals the exact signed product.
   assign word_x = {{B_W{word_in[PACK_W-1]}}, word_in};
   assign m_x    = {{PACK_W{m_in[B_W-1]}}, m_in};
   assign raw_d  = word_x * m_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         raw_q <= '0;
         m_q   <= '0;
         neg_q <= 1'b0;
      end else begin
         v_q <= v_in;
         if (v_in) begin
            raw_q <= raw_d;
            m_q   <= m_in;
            neg_q <= neg_in;
         end
      end
   end

   // R2: stage valid follows its input by one edge.
   assert_mult_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (v_q == $past(v_in)));

   // R6: a zero shared value clears the whole raw result.
   assert_mult_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(v_in) && (m_q == '0)) |-> (raw_q == '0));

endmodule

// File: rtl/dpu_split.sv
module dpu_split
   import dpu_pkg::*;
#(
   parameter int A_W  = 8,
   parameter int B_W  = 8,
   parameter int LO_W = 9
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 v_in,
   input  logic [raw_bits(A_W, LO_W, B_W)-1:0]  raw_in,
   input  logic [B_W-1:0]                       m_in,
   input  logic                                 neg_in,
   output logic                                 v_q,
   output logic [A_W+B_W-1:0]                   lo_q,
   output logic [A_W+B_W-1:0]                   hi_q
);
   localparam int RAW_W = raw_bits(A_W, LO_W, B_W);
   localparam int SEP   = sep_bits(LO_W, B_W);
   localparam int P_W   = A_W + B_W;

   logic [SEP-1:0] low_raw;
   logic [SEP-1:0] low_fix;
   logic [SEP-1:0] low_full;
   logic [P_W-1:0] hi_top;
   logic [P_W-1:0] hi_d;

   // Low part of the raw result; equals (unsigned low field) x shared value.
   assign low_raw  = raw_in[SEP-1:0];
   // Negative low multiplicand read as unsigned: remove shared << LO_W.
   assign low_fix  = neg_in ? {m_in, {LO_W{1'b0}}} : '0;
   assign low_full = low_raw - low_fix;

   // High field: bits above SEP, plus the borrow taken by a negative low part.
   assign hi_top = raw_in[RAW_W-1:SEP];
   assign hi_d   = hi_top + {{(P_W-1){1'b0}}, low_raw[SEP-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q  <= 1'b0;
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         v_q <= v_in;
         if (v_in) begin
            lo_q <= low_full[P_W-1:0];
            hi_q <= hi_d;
         end
      end
   end

   // R2: stage valid follows its input by one edge.
   assert_split_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (v_q == $past(v_in)));

   // R4: the corrected low product must fit the output width, so the bits
   // above it are copies of its sign.
   generate
      if (SEP > P_W) begin : g_fit_check
         assert_low_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
            v_in |-> ((low_full[SEP-1:P_W-1] == '0) || (&low_full[SEP-1:P_W-1])));
      end
   endgenerate

endmodule

// File: rtl/dual_product_unit.sv
module dual_product_unit
   import dpu_pkg::*;
#(
   parameter int A_W  = 8,
   parameter int B_W  = 8,
   parameter int LO_W = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic signed [A_W-1:0]       mcand_lo,
   input  logic signed [A_W-1:0]       mcand_hi,
   input  logic signed [B_W-1:0]       mplier,
   output logic                        out_valid,
   output logic signed [A_W+B_W-1:0]   prod_lo,
   output logic signed [A_W+B_W-1:0]   prod_hi
);
   localparam int PACK_W = pack_bits(A_W, LO_W, B_W);
   localparam int RAW_W  = raw_bits(A_W, LO_W, B_W);
   localparam int P_W    = A_W + B_W;

   // Elaboration-time parameter checks.
   generate
      if (A_W < 2) begin : g_bad_a
         $error("dual_product_unit: A_W must be at least 2");
      end
      if (B_W < 2) begin : g_bad_b
         $error("dual_product_unit: B_W must be at least 2");
      end
      if (LO_W < A_W) begin : g_bad_lo
         $error("dual_product_unit: LO_W must not be narrower than A_W");
      end
   endgenerate

   logic              s1_v, s1_neg;
   logic [PACK_W-1:0] s1_word;
   logic [B_W-1:0]    s1_m;
   logic              s2_v, s2_neg;
   logic [RAW_W-1:0]  s2_raw;
   logic [B_W-1:0]    s2_m;
   logic [P_W-1:0]    lo_u, hi_u;

   dpu_pack #(.A_W(A_W), .B_W(B_W), .LO_W(LO_W)) u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_in   (in_valid),
      .lo_in  (mcand_lo),
      .hi_in  (mcand_hi),
      .m_in   (mplier),
      .v_q    (s1_v),
      .word_q (s1_word),
      .m_q    (s1_m),
      .neg_q  (s1_neg)
   );

   dpu_mult #(.A_W(A_W), .B_W(B_W), .LO_W(LO_W)) u_mult (
      .clk     (clk),
      .rst_n   (rst_n),
      .v_in    (s1_v),
      .word_in (s1_word),
      .m_in    (s1_m),
      .neg_in  (s1_neg),
      .v_q     (s2_v),
      .raw_q   (s2_raw),
      .m_q     (s2_m),
      .neg_q   (s2_neg)
   );

   dpu_split #(.A_W(A_W), .B_W(B_W), .LO_W(LO_W)) u_split (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_in   (s2_v),
      .raw_in (s2_raw),
      .m_in   (s2_m),
      .neg_in (s2_neg),
      .v_q    (out_valid),
      .lo_q   (lo_u),
      .hi_q   (hi_u)
   );

   assign prod_lo = lo_u;
   assign prod_hi = hi_u;

   // Port-level checks; edges since reset release, saturating at 3.
   logic [1:0]            age;
   logic signed [P_W-1:0] lo_x, hi_x, m_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   assign lo_x = {{B_W{mcand_lo[A_W-1]}}, mcand_lo};
   assign hi_x = {{B_W{mcand_hi[A_W-1]}}, mcand_hi};
   assign m_x  = {{A_W{mplier[B_W-1]}}, mplier};

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   assert_hi_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd3) && out_valid) |-> (prod_hi == $past(hi_x, 3) * $past(m_x, 3)));

   assert_lo_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((age == 2'd3) && out_valid) |-> (prod_lo == $past(lo_x, 3) * $past(m_x, 3)));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(prod_lo) && $stable(prod_hi)));

endmodule

// File: tb/dual_product_unit_bench.sv
`timescale 1ns/1ps
module dual_product_unit_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // Default configuration
   logic               in_valid = 1'b0;
   logic signed [7:0]  mcand_lo = '0, mcand_hi = '0, mplier = '0;
   logic               out_valid;
   logic signed [15:0] prod_lo, prod_hi;

   dual_product_unit u_dual_product_unit (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .mcand_lo (mcand_lo), .mcand_hi (mcand_hi), .mplier (mplier),
      .out_valid (out_valid), .prod_lo (prod_lo), .prod_hi (prod_hi));

   // Wide configuration
   logic               w_in_valid = 1'b0;
   logic signed [11:0] w_lo = '0, w_hi = '0;
   logic signed [8:0]  w_m = '0;
   logic               w_out_valid;
   logic signed [20:0] w_prod_lo, w_prod_hi;

   dual_product_unit #(.A_W(12), .B_W(9), .LO_W(12)) u_dual_product_unit_wide (
      .clk (clk), .rst_n (rst_n), .in_valid (w_in_valid),
      .mcand_lo (w_lo), .mcand_hi (w_hi), .mplier (w_m),
      .out_valid (w_out_valid), .prod_lo (w_prod_lo), .prod_hi (w_prod_hi));

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Expected-value pipeline for the default instance (three entries deep).
   bit                 pv[3];
   logic signed [15:0] plo[3], phi[3];
   string              ptag[3];
   logic signed [15:0] last_lo = '0, last_hi = '0;

   task automatic step(input bit v, input logic signed [7:0] lo,
                       input logic signed [7:0] hi, input logic signed [7:0] m,
                       input string tag);
      logic signed [15:0] elo, ehi;
      @(negedge clk);
      chk(out_valid == pv[2], "R2", "out_valid", out_valid, pv[2]);
      if (pv[2]) begin
         chk(prod_lo == plo[2], ptag[2], "prod_lo", prod_lo, plo[2]);
         chk(prod_hi == phi[2], ptag[2], "prod_hi", prod_hi, phi[2]);
         last_lo = plo[2];
         last_hi = phi[2];
      end else begin
         chk(prod_lo == last_lo, "R7", "prod_lo held", prod_lo, last_lo);
         chk(prod_hi == last_hi, "R7", "prod_hi held", prod_hi, last_hi);
      end
      elo = lo * m;
      ehi = hi * m;
      for (int i = 2; i > 0; i--) begin
         pv[i] = pv[i-1]; plo[i] = plo[i-1]; phi[i] = phi[i-1]; ptag[i] = ptag[i-1];
      end
      pv[0] = v; plo[0] = elo; phi[0] = ehi; ptag[0] = tag;
      in_valid = v; mcand_lo = lo; mcand_hi = hi; mplier = m;
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) step(1'b0, 8'sh5a, -8'sd77, 8'sh33, "R7");
   endtask

   // Expected-value pipeline for the wide instance.
   bit                 wv[3];
   logic signed [20:0] wlo[3], whi[3];

   task automatic wstep(input bit v, input logic signed [11:0] lo,
                        input logic signed [11:0] hi, input logic signed [8:0] m);
      logic signed [20:0] elo, ehi;
      @(negedge clk);
      chk(w_out_valid == wv[2], "R8", "wide out_valid", w_out_valid, wv[2]);
      if (wv[2]) begin
         chk(w_prod_lo == wlo[2], "R8", "wide prod_lo", w_prod_lo, wlo[2]);
         chk(w_prod_hi == whi[2], "R8", "wide prod_hi", w_prod_hi, whi[2]);
      end
      elo = lo * m;
      ehi = hi * m;
      for (int i = 2; i > 0; i--) begin
         wv[i] = wv[i-1]; wlo[i] = wlo[i-1]; whi[i] = whi[i-1];
      end
      wv[0] = v; wlo[0] = elo; whi[0] = ehi;
      w_in_valid = v; w_lo = lo; w_hi = hi; w_m = m;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      chk(prod_lo == 0, "R1", "prod_lo in reset", prod_lo, 0);
      chk(prod_hi == 0, "R1", "prod_hi in reset", prod_hi, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0, "R1");
   endtask

   task automatic t_latency();
      step(1'b1, 8'sd5, -8'sd3, 8'sd7, "R2");
      for (int i = 0; i < 4; i++) step(1'b0, -8'sd1, 8'sd100, -8'sd9, "R2");
   endtask

   task automatic t_doc_vector();
      step(1'b1, -8'sd43, -8'sd90, 8'sd23, "R5");
      flush();
      @(negedge clk);
      chk(prod_hi == -16'sd2070, "R5", "prod_hi", prod_hi, -2070);
      chk(prod_lo == -16'sd989, "R5", "prod_lo", prod_lo, -989);
   endtask

   task automatic t_extremes();
      step(1'b1, -8'sd128, -8'sd128, -8'sd128, "R6");
      step(1'b1, 8'sd127, -8'sd128, -8'sd128, "R6");
      step(1'b1, -8'sd128, 8'sd127, 8'sd127, "R6");
      step(1'b1, -8'sd1, -8'sd1, -8'sd128, "R6");
      step(1'b1, -8'sd128, 8'sd0, 8'sd127, "R6");
      step(1'b1, 8'sd127, 8'sd127, -8'sd1, "R6");
      step(1'b1, -8'sd1, 8'sd127, 8'sd0, "R6");
      flush();
   endtask

   task automatic t_hold();
      step(1'b1, -8'sd17, 8'sd29, -8'sd11, "R7");
      for (int i = 0; i < 6; i++)
         step(1'b0, 8'(i * 37), 8'(i * 53 + 1), 8'(i * 71 + 3), "R7");
   endtask

   task automatic t_sweep_low();
      for (int m = -128; m < 128; m++)
         for (int l = -128; l < 128; l++)
            step(1'b1, 8'(l), -8'sd128, 8'(m), "R4");
      flush();
   endtask

   task automatic t_sweep_high();
      for (int m = -128; m < 128; m++)
         for (int h = -128; h < 128; h++)
            step(1'b1, -8'sd1, 8'(h), 8'(m), "R3");
      flush();
   endtask

   task automatic t_wide();
      wstep(1'b1, -12'sd2048, -12'sd2048, -9'sd256);
      wstep(1'b1, 12'sd2047, -12'sd2048, 9'sd255);
      wstep(1'b1, -12'sd1, 12'sd2047, -9'sd256);
      wstep(1'b1, -12'sd1000, -12'sd3, 9'sd1);
      for (int i = 0; i < 600; i++)
         wstep(1'b1, 12'($urandom), 12'($urandom), 9'($urandom));
      for (int i = 0; i < 3; i++) wstep(1'b0, '0, '0, '0);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 3; i++) begin
         pv[i] = 1'b0; wv[i] = 1'b0; plo[i] = '0; phi[i] = '0;
         wlo[i] = '0; whi[i] = '0; ptag[i] = "";
      end
      t_reset();
      t_latency();
      t_doc_vector();
      t_extremes();
      t_hold();
      t_wide();
      t_sweep_low();
      t_sweep_high();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule